// File: doc/BRIEF.md
# DQS oscillator measurement sequencer

This block is the control sequencer that a DRAM controller uses to measure the DQS interval oscillator of every rank. A request may come from the initialization flow, a frequency-change flow, a software request bit or a periodic trigger. Requests count only while the oscillator feature is enabled. A request that arrives while a measurement is running waits as pending and is served once the sequencer is idle again.

For each rank in ascending order the sequencer does the following. If the request came from initialization, it first writes the run-length mode register (MR23). It then sends a start MPC to the whole rank and waits the programmed period plus a settle time chosen by the active frequency set point. Next it reads MR18 and MR19, waiting the read latency after each read and capturing one byte per device. At the end it emits a one-cycle done pulse that carries the rank, the request source and the 16-bit count of each device. Low-power entry is blocked for the whole time the sequencer is busy. Commands leave through a valid/ready handshake, and each wait counter starts only once its command has been accepted.

Top module: `dqs_osc_seq`

## Requirements
- R1: After reset the block is idle: `cmd_valid_o`, `done_o`, `lp_block_o` and `sw_req_o` are all 0.
- R2: While `osc_en_i` is 0, request pulses are ignored. No command is issued, `sw_req_o` stays 0, and nothing is remembered, so enabling later starts no measurement.
- R3: Requests that arrive while busy, or several at once, are held as pending. They are served one at a time after the block returns to idle, in the order init (source 0), frequency change (1), software (2), periodic (3).
- R4: `sw_req_set_i` with the feature enabled sets `sw_req_o` in the next cycle. The bit clears by itself when its request is accepted.
- R5: Only for an init request, each rank's sequence starts with an MRW (type 0) to mode register 23 that carries `mr23_data_i`.
- R6: Ranks are handled from 0 upward. Each rank's commands run in a fixed order: MRW (init only), MPC (type 1), MRR (type 2) of register 18, then MRR of register 19, all carrying that rank on `cmd_rank_o`.
- R7: The MR18 read first appears exactly `period_i` + settle + 2 cycles after the cycle in which the MPC was accepted. The settle value is `settle_f0_i`, `settle_f1_i` or `settle_f2_i` for `fsp_i` = 0, 1, or 2/3.
- R8: The MR19 read first appears `mrr_lat_i` + 2 cycles after MR18 is accepted. Each device's bytes are sampled `mrr_lat_i` + 1 cycles after their read is accepted. `count_o[16d+15:16d]` reports {MR19 byte, MR18 byte} of device d, where device d's byte sits at `mrr_data_i[8d+7:8d]`.
- R9: `done_o` is high for exactly one cycle per rank, `mrr_lat_i` + 2 cycles after MR19 is accepted, with `done_rank_o` and `done_src_o` valid.
- R10: `lp_block_o` is high whenever a command is offered or a done pulse is shown, and returns to 0 after the last rank.
- R11: An offered command stays valid with an unchanged payload until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | Feature enable |
| init_req_i | input | 1 | Init request pulse |
| dfs_req_i | input | 1 | Frequency-change request pulse |
| sw_req_set_i | input | 1 | Sets the software request bit |
| per_req_i | input | 1 | Periodic trigger pulse |
| sw_req_o | output | 1 | Software request bit |
| mr23_data_i | input | 8 | Oscillator run-length value |
| period_i | input | PER_W | Measurement period count |
| settle_f0_i | input | SET_W | Settle time, set point 0 |
| settle_f1_i | input | SET_W | Settle time, set point 1 |
| settle_f2_i | input | SET_W | Settle time, set point 2 |
| fsp_i | input | 2 | Active frequency set point |
| mrr_lat_i | input | LAT_W | Mode-register read latency |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_type_o | output | 2 | 0 MRW, 1 MPC, 2 MRR |
| cmd_rank_o | output | RANK_W | Target rank |
| cmd_mr_o | output | 8 | Mode register address |
| cmd_data_o | output | 8 | Write data or MPC opcode |
| mrr_data_i | input | NUM_DEV*8 | Read bytes, one per device |
| lp_block_o | output | 1 | Forbids low-power entry |
| done_o | output | 1 | Rank measurement complete |
| done_rank_o | output | RANK_W | Rank of this result |
| done_src_o | output | 2 | Request source of this result |
| count_o | output | NUM_DEV*16 | Oscillator count per device |

## Verification
The assertions assume that `mr23_data_i` is held steady while an MRW is waiting to be accepted. They also assume that `cmd_ready_i` is a plain pulse level with no dependence on the payload. The bench changes the configuration inputs only while the block is idle, and it drives ready either always high or on a fixed one-in-three pattern. Read data is changed only when a read is accepted and then held until after the latency wait, so each sampled byte is unambiguous.

// File: rtl/dqs_osc_pkg.sv
package dqs_osc_pkg;
  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    CMD_MRW = 2'd0,
    CMD_MPC = 2'd1,
    CMD_MRR = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_INIT = 2'd0,
    SRC_DFS  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_PER  = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MRW,
    ST_MPC,
    ST_OSC_WAIT,
    ST_RD_LO,
    ST_LAT_LO,
    ST_RD_HI,
    ST_LAT_HI,
    ST_DONE
  } st_e;
endpackage

// File: rtl/dqs_osc_req_arb.sv
module dqs_osc_req_arb
  import dqs_osc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       init_i,
  input  logic       dfs_i,
  input  logic       sw_set_i,
  input  logic       per_i,
  input  logic       take_i,
  output logic       pend_o,
  output logic [1:0] src_o,
  output logic       sw_bit_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d, req_in;

  assign req_in = {per_i, sw_set_i, dfs_i, init_i};

  // lowest index wins
  always_comb begin
    src_o = 2'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) src_o = 2'(i);
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d[src_o] = 1'b0;
    if (en_i) pend_d = pend_d | req_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o   = |pend_q;
  assign sw_bit_o = pend_q[SRC_SW];
endmodule

// File: rtl/dqs_osc_timer.sv
module dqs_osc_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dqs_osc_capture.sv
module dqs_osc_capture #(
  parameter int NUM_DEV = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_lo_i,
  input  logic                    cap_hi_i,
  input  logic [NUM_DEV*8-1:0]    data_i,
  output logic [NUM_DEV*16-1:0]   cnt_o
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [7:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (cap_lo_i) lo_q <= data_i[d*8 +: 8];
        if (cap_hi_i) hi_q <= data_i[d*8 +: 8];
      end
    end
    assign cnt_o[d*16 +: 16] = {hi_q, lo_q};
  end
endmodule

// File: rtl/dqs_osc_seq.sv
module dqs_osc_seq
  import dqs_osc_pkg::*;
#(
  parameter int          NUM_RANKS = 2,
  parameter int          NUM_DEV   = 2,
  parameter int          PER_W     = 15,
  parameter int          SET_W     = 8,
  parameter int          LAT_W     = 4,
  parameter logic [7:0]  MPC_START = 8'h4B,
  localparam int         RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   osc_en_i,
  input  logic                   init_req_i,
  input  logic                   dfs_req_i,
  input  logic                   sw_req_set_i,
  input  logic                   per_req_i,
  output logic                   sw_req_o,
  input  logic [7:0]             mr23_data_i,
  input  logic [PER_W-1:0]       period_i,
  input  logic [SET_W-1:0]       settle_f0_i,
  input  logic [SET_W-1:0]       settle_f1_i,
  input  logic [SET_W-1:0]       settle_f2_i,
  input  logic [1:0]             fsp_i,
  input  logic [LAT_W-1:0]       mrr_lat_i,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  output logic [1:0]             cmd_type_o,
  output logic [RANK_W-1:0]      cmd_rank_o,
  output logic [7:0]             cmd_mr_o,
  output logic [7:0]             cmd_data_o,
  input  logic [NUM_DEV*8-1:0]   mrr_data_i,
  output logic                   lp_block_o,
  output logic                   done_o,
  output logic [RANK_W-1:0]      done_rank_o,
  output logic [1:0]             done_src_o,
  output logic [NUM_DEV*16-1:0]  count_o
);
  localparam int CNT_W = ((PER_W > SET_W) ? PER_W : SET_W) + 1;
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);

  st_e               state_q, state_d;
  logic [RANK_W-1:0] rank_q, rank_d;
  logic [1:0]        src_q, src_d;
  logic              pend, take, hs, tmr_zero, tmr_load, cap_lo, cap_hi;
  logic [1:0]        arb_src;
  logic [SET_W-1:0]  settle;
  logic [CNT_W-1:0]  tmr_val;

  dqs_osc_req_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (osc_en_i),
    .init_i   (init_req_i),
    .dfs_i    (dfs_req_i),
    .sw_set_i (sw_req_set_i),
    .per_i    (per_req_i),
    .take_i   (take),
    .pend_o   (pend),
    .src_o    (arb_src),
    .sw_bit_o (sw_req_o)
  );

  always_comb begin
    unique case (fsp_i)
      2'd0:    settle = settle_f0_i;
      2'd1:    settle = settle_f1_i;
      default: settle = settle_f2_i;
    endcase
  end

  assign take = (state_q == ST_IDLE) && osc_en_i && pend;
  assign hs   = cmd_valid_o && cmd_ready_i;

  // command presentation
  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_type_o  = CMD_MRR;
    cmd_mr_o    = 8'd0;
    cmd_data_o  = 8'd0;
    unique case (state_q)
      ST_MRW:   begin cmd_valid_o = 1'b1; cmd_type_o = CMD_MRW; cmd_mr_o = 8'd23; cmd_data_o = mr23_data_i; end
      ST_MPC:   begin cmd_valid_o = 1'b1; cmd_type_o = CMD_MPC; cmd_data_o = MPC_START; end
      ST_RD_LO: begin cmd_valid_o = 1'b1; cmd_mr_o = 8'd18; end
      ST_RD_HI: begin cmd_valid_o = 1'b1; cmd_mr_o = 8'd19; end
      default: ;
    endcase
  end
  assign cmd_rank_o = rank_q;

  always_comb begin
    state_d  = state_q;
    rank_d   = rank_q;
    src_d    = src_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(mrr_lat_i);
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        src_d   = arb_src;
        rank_d  = '0;
        state_d = (arb_src == SRC_INIT) ? ST_MRW : ST_MPC;
      end
      ST_MRW: if (hs) state_d = ST_MPC;
      ST_MPC: if (hs) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(period_i) + CNT_W'(settle);
        state_d  = ST_OSC_WAIT;
      end
      ST_OSC_WAIT: if (tmr_zero) state_d = ST_RD_LO;
      ST_RD_LO: if (hs) begin tmr_load = 1'b1; state_d = ST_LAT_LO; end
      ST_LAT_LO: if (tmr_zero) begin cap_lo = 1'b1; state_d = ST_RD_HI; end
      ST_RD_HI: if (hs) begin tmr_load = 1'b1; state_d = ST_LAT_HI; end
      ST_LAT_HI: if (tmr_zero) begin cap_hi = 1'b1; state_d = ST_DONE; end
      ST_DONE: begin
        if (rank_q == LAST_RANK) state_d = ST_IDLE;
        else begin
          rank_d  = rank_q + 1'b1;
          state_d = (src_q == SRC_INIT) ? ST_MRW : ST_MPC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rank_q  <= '0;
      src_q   <= SRC_INIT;
    end else begin
      state_q <= state_d;
      rank_q  <= rank_d;
      src_q   <= src_d;
    end
  end

  dqs_osc_timer #(.W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  dqs_osc_capture #(.NUM_DEV(NUM_DEV)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_lo_i (cap_lo),
    .cap_hi_i (cap_hi),
    .data_i   (mrr_data_i),
    .cnt_o    (count_o)
  );

  assign lp_block_o  = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign done_rank_o = rank_q;
  assign done_src_o  = src_q;
endmodule

// File: rtl/dqs_osc_seq_chk.sv
module dqs_osc_seq_chk #(
  parameter int NUM_RANKS = 2,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              osc_en_i,
  input logic              sw_req_set_i,
  input logic              sw_req_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [1:0]        cmd_type_o,
  input logic [RANK_W-1:0] cmd_rank_o,
  input logic [7:0]        cmd_mr_o,
  input logic [7:0]        cmd_data_o,
  input logic              lp_block_o,
  input logic              done_o,
  input logic [1:0]        src_q
);
  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_type_o) &&
      $stable(cmd_rank_o) && $stable(cmd_mr_o) && $stable(cmd_data_o));

  // R10
  lp_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || done_o) |-> lp_block_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  mrw_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_type_o == 2'd0 |-> cmd_mr_o == 8'd23 && src_q == 2'd0);

  // R6
  rank_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> int'(cmd_rank_o) < NUM_RANKS);

  // R2
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_block_o && !osc_en_i |=> !lp_block_o);

  // R4
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i && sw_req_set_i |=> sw_req_o);
endmodule

bind dqs_osc_seq dqs_osc_seq_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .osc_en_i     (osc_en_i),
  .sw_req_set_i (sw_req_set_i),
  .sw_req_o     (sw_req_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_type_o   (cmd_type_o),
  .cmd_rank_o   (cmd_rank_o),
  .cmd_mr_o     (cmd_mr_o),
  .cmd_data_o   (cmd_data_o),
  .lp_block_o   (lp_block_o),
  .done_o       (done_o),
  .src_q        (src_q)
);

// File: tb/dqs_osc_seq_tb.sv
`timescale 1ns/1ps
module dqs_osc_seq_tb;
  localparam int NR = 2;
  localparam int ND = 2;
  localparam int PW = 15;
  localparam int SW = 8;
  localparam int LW = 4;
  localparam int MAXL = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, init_req = 1'b0, dfs_req = 1'b0, sw_set = 1'b0, per_req = 1'b0;
  logic sw_bit;
  logic [7:0] mr23 = 8'hA5;
  logic [PW-1:0] period = '0;
  logic [SW-1:0] s0 = 8'd3, s1 = 8'd7, s2 = 8'd200;
  logic [1:0] fsp = 2'd0;
  logic [LW-1:0] lat = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_type;
  logic [0:0] cmd_rank;
  logic [7:0] cmd_mr, cmd_data;
  logic [ND*8-1:0] mrr_data = '0;
  logic lp_block, done;
  logic [0:0] done_rank;
  logic [1:0] done_src;
  logic [ND*16-1:0] count;

  always #10 clk = ~clk;

  dqs_osc_seq #(.NUM_RANKS(NR), .NUM_DEV(ND), .PER_W(PW), .SET_W(SW), .LAT_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .init_req_i(init_req),
    .dfs_req_i(dfs_req), .sw_req_set_i(sw_set), .per_req_i(per_req), .sw_req_o(sw_bit),
    .mr23_data_i(mr23), .period_i(period), .settle_f0_i(s0), .settle_f1_i(s1),
    .settle_f2_i(s2), .fsp_i(fsp), .mrr_lat_i(lat), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_type_o(cmd_type), .cmd_rank_o(cmd_rank),
    .cmd_mr_o(cmd_mr), .cmd_data_o(cmd_data), .mrr_data_i(mrr_data),
    .lp_block_o(lp_block), .done_o(done), .done_rank_o(done_rank),
    .done_src_o(done_src), .count_o(count)
  );

  int n_chk = 0, n_pass = 0;
  int cyc = 0;
  int stall = 0;
  int n_hs = 0, n_dn = 0, n_vld = 0, lp_bad = 0;
  bit in_cmd = 1'b0;
  int first_c = 0;
  int hs_type[MAXL], hs_rank[MAXL], hs_mr[MAXL], hs_data[MAXL], hs_cyc[MAXL], hs_first[MAXL];
  int dn_cyc[MAXL], dn_rank[MAXL], dn_src[MAXL], dn_lp[MAXL];
  logic [ND*16-1:0] dn_cnt[MAXL];

  function automatic logic [7:0] fb(input int idx, input int d);
    return 8'((idx * 29 + d * 71 + 5) % 256);
  endfunction

  function automatic int se(input int f);
    return (f == 0) ? int'(s0) : (f == 1) ? int'(s1) : int'(s2);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // command responder and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 1'b0;
    end else begin
      cmd_ready = (stall == 0) ? 1'b1 : ((cyc % 3) == 2);
      if ((cmd_valid || done) && !lp_block) lp_bad++;
      if (cmd_valid) begin
        n_vld++;
        if (!in_cmd) begin in_cmd = 1'b1; first_c = cyc; end
        if (cmd_ready && n_hs < MAXL) begin
          hs_type[n_hs] = int'(cmd_type); hs_rank[n_hs] = int'(cmd_rank);
          hs_mr[n_hs] = int'(cmd_mr); hs_data[n_hs] = int'(cmd_data);
          hs_cyc[n_hs] = cyc; hs_first[n_hs] = first_c;
          if (cmd_type == 2'd2)
            for (int d = 0; d < ND; d++) mrr_data[d*8 +: 8] = fb(n_hs, d);
          in_cmd = 1'b0;
          n_hs++;
        end
      end
      if (done && n_dn < MAXL) begin
        dn_cyc[n_dn] = cyc; dn_rank[n_dn] = int'(done_rank); dn_src[n_dn] = int'(done_src);
        dn_lp[n_dn] = int'(lp_block); dn_cnt[n_dn] = count;
        n_dn++;
      end
    end
  end

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act == exp) n_pass++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic pulse(input bit i, input bit d, input bit s, input bit p);
    @(negedge clk);
    init_req = i; dfs_req = d; sw_set = s; per_req = p;
    @(negedge clk);
    init_req = 0; dfs_req = 0; sw_set = 0; per_req = 0;
  endtask

  task automatic wait_dn(input int target);
    while (n_dn < target) @(negedge clk);
    while (lp_block) @(negedge clk);
  endtask

  task automatic check_run(input int hb, input int db, input int src, input int wn,
                           input int lt, output int nh);
    int i;
    i = hb;
    for (int r = 0; r < NR; r++) begin
      int ig, i18, i19, dn;
      if (src == 0) begin
        chk_eq("R5 mrw type", hs_type[i], 0);
        chk_eq("R5 mrw addr", hs_mr[i], 23);
        chk_eq("R5 mrw data", hs_data[i], int'(mr23));
        chk_eq("R6 mrw rank", hs_rank[i], r);
        i++;
      end
      chk_eq("R6 mpc type", hs_type[i], 1);
      chk_eq("R6 mpc rank", hs_rank[i], r);
      ig = i; i++;
      chk_eq("R6 rd18 type", hs_type[i], 2);
      chk_eq("R6 rd18 addr", hs_mr[i], 18);
      chk_eq("R6 rd18 rank", hs_rank[i], r);
      chk_eq("R7 osc wait", hs_first[i] - hs_cyc[ig], wn + 2);
      i18 = i; i++;
      chk_eq("R6 rd19 addr", hs_mr[i], 19);
      chk_eq("R6 rd19 rank", hs_rank[i], r);
      chk_eq("R8 lat wait", hs_first[i] - hs_cyc[i18], lt + 2);
      i19 = i; i++;
      dn = db + r;
      chk_eq("R9 done rank", dn_rank[dn], r);
      chk_eq("R9 done src", dn_src[dn], src);
      chk_eq("R9 done time", dn_cyc[dn] - hs_cyc[i19], lt + 2);
      chk_eq("R10 lp at done", dn_lp[dn], 1);
      for (int d = 0; d < ND; d++)
        chk_eq("R8 count", dn_cnt[dn][d*16 +: 16], {fb(i19, d), fb(i18, d)});
    end
    chk_eq("R9 one pulse per rank", n_dn - db >= NR, 1);
    chk_eq("R10 idle after", lp_block, 0);
    nh = i;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  initial begin
    int hb, db, nh, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_eq("R1 valid", cmd_valid, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 lp", lp_block, 0);
    chk_eq("R1 sw bit", sw_bit, 0);

    // R2 disabled
    v0 = n_vld;
    pulse(1, 1, 1, 1);
    repeat (40) @(negedge clk);
    chk_eq("R2 no cmd while off", n_vld - v0, 0);
    chk_eq("R2 sw bit while off", sw_bit, 0);
    chk_eq("R2 lp while off", lp_block, 0);
    osc_en = 1'b1;
    repeat (40) @(negedge clk);
    chk_eq("R2 nothing latched", n_vld - v0, 0);

    // init run
    period = 15'd5; lat = 4'd3; fsp = 2'd0;
    hb = n_hs; db = n_dn;
    pulse(1, 0, 0, 0);
    wait_dn(db + NR);
    check_run(hb, db, 0, 5 + se(0), 3, nh);

    // sweep set point and latency, alternate stalling
    for (int f = 0; f < 4; f++) begin
      for (int li = 0; li < 4; li++) begin
        int lv;
        lv = (li == 0) ? 0 : (li == 1) ? 2 : (li == 2) ? 9 : 15;
        fsp = 2'(f); lat = 4'(lv); stall = (f + li) % 2;
        hb = n_hs; db = n_dn;
        pulse(0, 1, 0, 0);
        wait_dn(db + NR);
        check_run(hb, db, 1, 5 + se(f), lv, nh);
      end
    end

    // period sweep with periodic trigger
    fsp = 2'd2; lat = 4'd1; stall = 0;
    for (int pi = 0; pi < 4; pi++) begin
      int pv;
      pv = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 40 : 32767;
      period = 15'(pv);
      hb = n_hs; db = n_dn;
      pulse(0, 0, 0, 1);
      wait_dn(db + NR);
      check_run(hb, db, 3, pv + se(2), 1, nh);
    end

    // R4 / R3: software request while busy
    period = 15'd4; fsp = 2'd1; lat = 4'd2;
    hb = n_hs; db = n_dn;
    pulse(0, 0, 0, 1);
    repeat (3) @(negedge clk);
    pulse(0, 0, 1, 0);
    chk_eq("R4 sw bit set", sw_bit, 1);
    while (n_dn < db + NR) @(negedge clk);
    repeat (3) @(negedge clk);
    chk_eq("R4 sw bit cleared", sw_bit, 0);
    chk_eq("R3 pending served", lp_block, 1);
    wait_dn(db + 2 * NR);
    check_run(hb, db, 3, 4 + se(1), 2, nh);
    check_run(nh, db + NR, 2, 4 + se(1), 2, nh);

    // R3 simultaneous requests
    stall = 1;
    hb = n_hs; db = n_dn;
    pulse(1, 0, 1, 1);
    wait_dn(db + 3 * NR);
    check_run(hb, db, 0, 4 + se(1), 2, nh);
    check_run(nh, db + NR, 2, 4 + se(1), 2, nh);
    check_run(nh, db + 2 * NR, 3, 4 + se(1), 2, nh);

    chk_eq("R10 lp held while active", lp_bad, 0);
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule